// File: doc/BRIEF.md
# Machine-Cycle Watchdog with Sleep Gating

This block supervises the program running on a small 8-bit controller core. A divide-by-`CLK_DIV` prescaler turns the system clock into machine-cycle ticks. A tick counter runs against a limit taken from a 3-bit select field. When the limit is reached, the block drives a chip-reset pulse of fixed length.

Software selects the timeout through a register on the special-function-register (SFR) bus. It arms and services the watchdog by writing a two-byte key to a second register.

Two power-mode inputs gate the count:
- While the core is in deep sleep, the oscillator is stopped, so the prescaler and the counter stand still.
- If deep sleep ends while the wake interrupt line is still held low, counting stays frozen until that line is released high.

In light sleep nothing changes, and the watchdog keeps counting.

Top module: `mcu_watchdog`

## Requirements
- R1: After the synchronous reset `rst`, the select field is 0, the watchdog is disabled and `wdt_rst` is low. A disabled watchdog never raises `wdt_rst`, however long it waits.
- R2: The select register sits at SFR address A7h. Bits 2:0 can be written. Bits 7:3 read as 0 and writes to them are ignored. `sfr_rdata` returns, one clock after `sfr_addr` is presented, the value of the addressed register. Every other address, including the key register, reads 0.
- R3: Two consecutive writes to the key register at address A6h, first 1Eh and then E1h, enable the watchdog and clear both the prescaler and the tick counter on the edge of the E1h write.
- R4: With select value n, `wdt_rst` rises on the edge `CLK_DIV*(2^(SEL_BASE+n)-1)` unfrozen clocks after the edge of the enabling or servicing write.
- R5: Writing E1h without a directly preceding 1Eh to the key register has no effect. Any byte other than E1h written after 1Eh aborts the sequence. A repeated 1Eh re-arms it. Writes to other addresses leave the sequence state unchanged.
- R6: Once enabled, the watchdog can be stopped only by `rst`. Repeating the key sequence restarts the full timeout from that edge.
- R7: `wdt_rst` stays high for exactly `RST_LEN` clocks (96 by default). The watchdog then ends up disabled and raises no further reset.
- R8: Every clock edge on which `pd_mode` is high freezes both the prescaler and the counter, which delays the timeout by exactly that many clocks.
- R9: If `pd_mode` falls while `wake_irq_n` is low, counting remains frozen on every edge until `wake_irq_n` is first sampled high. If `wake_irq_n` is high on the last deep-sleep edge, no such hold occurs, and later low levels on the line do not freeze the count.
- R10: A key-sequence completion on the same edge as the timeout tick wins. No reset is raised and a full timeout restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high chip reset |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_addr | input | 8 | SFR address for writes and reads |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | Registered read data of the addressed register |
| pd_mode | input | 1 | Deep-sleep indication; the clock is considered stopped |
| wake_irq_n | input | 1 | Active-low level of the external wake interrupt line |
| wdt_rst | output | 1 | Registered chip-reset request pulse |

## Verification
The two functions that can meet on one edge are the servicing of the watchdog (the E1h key write) and the final tick that would trigger a reset.

The bench provokes the collision as follows:
1. It enables the watchdog.
2. It writes 1Eh.
3. It idles until one clock before the computed expiry edge.
4. It writes E1h so that this write lands exactly on the expiry edge.

The bench then judges two things: that `wdt_rst` stays low after that edge, and that the next expiry comes a full timeout later.

The same style of arithmetic, counting unfrozen edges, is applied to random deep-sleep and wake-line patterns.

// File: rtl/mcu_wdt_pkg.sv
package mcu_wdt_pkg;
  localparam int SFR_W = 8;
  localparam logic [SFR_W-1:0] KEY_FIRST  = 8'h1E;
  localparam logic [SFR_W-1:0] KEY_SECOND = 8'hE1;

  typedef enum logic [0:0] {
    KEY_IDLE  = 1'b0,
    KEY_ARMED = 1'b1
  } key_state_t;
endpackage

// File: rtl/mcu_wdt_sfr.sv
module mcu_wdt_sfr
  import mcu_wdt_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter logic [SFR_W-1:0] SEL_ADDR  = 8'hA7,
  parameter logic [SFR_W-1:0] KICK_ADDR = 8'hA6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [SFR_W-1:0] addr,
  input  logic [SFR_W-1:0] wdata,
  output logic [SFR_W-1:0] rdata,
  output logic [SEL_W-1:0] sel,
  output logic             kick
);
  key_state_t key_q;
  logic sel_hit, key_hit;

  assign sel_hit = (addr == SEL_ADDR);
  assign key_hit = wr && (addr == KICK_ADDR);
  // completion of the two-byte key
  assign kick = key_hit && (key_q == KEY_ARMED) && (wdata == KEY_SECOND);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel   <= '0;
      key_q <= KEY_IDLE;
      rdata <= '0;
    end else begin
      if (wr && sel_hit) sel <= wdata[SEL_W-1:0];
      if (key_hit) key_q <= (wdata == KEY_FIRST) ? KEY_ARMED : KEY_IDLE;
      rdata <= sel_hit ? {{(SFR_W-SEL_W){1'b0}}, sel} : '0;
    end
  end
endmodule

// File: rtl/mcu_wdt_gate.sv
module mcu_wdt_gate #(
  parameter int CLK_DIV = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clear,
  input  logic pd_mode,
  input  logic wake_irq_n,
  output logic tick,
  output logic hold_q
);
  localparam int PW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(CLK_DIV - 1);

  logic [PW-1:0] pre_q;
  logic freeze;

  // stopped oscillator, or wake line still low after deep sleep
  assign freeze = pd_mode || (hold_q && !wake_irq_n);
  assign tick   = run && !freeze && (pre_q == PRE_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b0;
    end else if (pd_mode) begin
      hold_q <= !wake_irq_n;
    end else if (wake_irq_n) begin
      hold_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear || !run) begin
      pre_q <= '0;
    end else if (!freeze) begin
      pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/mcu_wdt_count.sv
module mcu_wdt_count #(
  parameter int SEL_W    = 3,
  parameter int SEL_BASE = 14,
  parameter int RST_LEN  = 96,
  parameter int CNT_W    = SEL_BASE + (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic             tick,
  input  logic             kick,
  output logic             en_q,
  output logic             pulse_q,
  output logic [CNT_W-1:0] cnt_q
);
  localparam int LW = $clog2(RST_LEN + 1);
  localparam logic [SEL_W-1:0] MAX_SEL = '1;

  logic [LW-1:0]    len_q;
  logic [CNT_W-1:0] limit;
  logic [CNT_W:0]   next_cnt;
  logic             expire;

  // 2^(SEL_BASE+sel)-1 as a right-shifted all-ones word
  assign limit    = {CNT_W{1'b1}} >> (MAX_SEL - sel);
  assign next_cnt = {1'b0, cnt_q} + 1'b1;
  assign expire   = next_cnt >= {1'b0, limit};

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      pulse_q <= 1'b0;
      cnt_q   <= '0;
      len_q   <= '0;
    end else if (pulse_q) begin
      if (len_q == '0) begin
        pulse_q <= 1'b0;
        en_q    <= 1'b0;
        cnt_q   <= '0;
      end else begin
        len_q <= len_q - 1'b1;
      end
    end else if (kick) begin
      en_q  <= 1'b1;
      cnt_q <= '0;
    end else if (en_q && tick) begin
      if (expire) begin
        pulse_q <= 1'b1;
        len_q   <= LW'(RST_LEN - 1);
      end else begin
        cnt_q <= next_cnt[CNT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/mcu_watchdog.sv
module mcu_watchdog #(
  parameter int CLK_DIV  = 12,
  parameter int SEL_BASE = 14,
  parameter int SEL_W    = 3,
  parameter int RST_LEN  = 96,
  parameter logic [7:0] SEL_ADDR  = 8'hA7,
  parameter logic [7:0] KICK_ADDR = 8'hA6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sfr_wr,
  input  logic [7:0] sfr_addr,
  input  logic [7:0] sfr_wdata,
  output logic [7:0] sfr_rdata,
  input  logic       pd_mode,
  input  logic       wake_irq_n,
  output logic       wdt_rst
);
  localparam int CNT_W = SEL_BASE + (1 << SEL_W) - 1;

  logic [SEL_W-1:0] sel;
  logic             kick, tick, hold_q, en_q, pulse_q;
  logic [CNT_W-1:0] cnt_q;

  mcu_wdt_sfr #(
    .SEL_W(SEL_W), .SEL_ADDR(SEL_ADDR), .KICK_ADDR(KICK_ADDR)
  ) u_sfr (
    .clk(clk), .rst(rst), .wr(sfr_wr), .addr(sfr_addr), .wdata(sfr_wdata),
    .rdata(sfr_rdata), .sel(sel), .kick(kick)
  );

  mcu_wdt_gate #(
    .CLK_DIV(CLK_DIV)
  ) u_gate (
    .clk(clk), .rst(rst), .run(en_q && !pulse_q), .clear(kick),
    .pd_mode(pd_mode), .wake_irq_n(wake_irq_n), .tick(tick), .hold_q(hold_q)
  );

  mcu_wdt_count #(
    .SEL_W(SEL_W), .SEL_BASE(SEL_BASE), .RST_LEN(RST_LEN), .CNT_W(CNT_W)
  ) u_count (
    .clk(clk), .rst(rst), .sel(sel), .tick(tick), .kick(kick),
    .en_q(en_q), .pulse_q(pulse_q), .cnt_q(cnt_q)
  );

  assign wdt_rst = pulse_q;
endmodule

// File: rtl/mcu_watchdog_chk.sv
module mcu_watchdog_chk #(
  parameter int CW      = 21,
  parameter int RST_LEN = 96
) (
  input logic          clk,
  input logic          rst,
  input logic          sfr_wr,
  input logic [7:0]    sfr_rdata,
  input logic          pd_mode,
  input logic          wake_irq_n,
  input logic          wdt_rst,
  input logic          en_q,
  input logic          hold_q,
  input logic [CW-1:0] cnt_q
);
  int plen;

  always_ff @(posedge clk) begin
    if (rst) plen <= 0;
    else if (wdt_rst) plen <= plen + 1;
    else plen <= 0;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!wdt_rst && !en_q));

  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
    sfr_rdata[7:3] == 5'd0);

  assert_pulse_len_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(wdt_rst) |-> (plen == RST_LEN));

  assert_pulse_cap_R7: assert property (@(posedge clk) disable iff (rst)
    plen <= RST_LEN);

  assert_off_silent_R7: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !wdt_rst) |=> !wdt_rst);

  assert_sleep_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (pd_mode && !wdt_rst && !sfr_wr) |=> $stable(cnt_q));

  assert_sleep_no_fire_R8: assert property (@(posedge clk) disable iff (rst)
    pd_mode |=> !$rose(wdt_rst));

  assert_wake_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (hold_q && !wake_irq_n && !pd_mode && !wdt_rst && !sfr_wr) |=> $stable(cnt_q));
endmodule

bind mcu_watchdog mcu_watchdog_chk #(.CW(CNT_W), .RST_LEN(RST_LEN)) u_chk (
  .clk(clk), .rst(rst), .sfr_wr(sfr_wr), .sfr_rdata(sfr_rdata),
  .pd_mode(pd_mode), .wake_irq_n(wake_irq_n), .wdt_rst(wdt_rst),
  .en_q(en_q), .hold_q(hold_q), .cnt_q(cnt_q)
);

// File: tb/mcu_watchdog_test.sv
module mcu_watchdog_test;
  localparam int DIV  = 4;
  localparam int BASE = 4;
  localparam int PLEN = 96;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sfr_wr = 1'b0;
  logic [7:0] sfr_addr = 8'h00;
  logic [7:0] sfr_wdata = 8'h00;
  logic       pd_mode = 1'b0;
  logic       wake_irq_n = 1'b1;
  wire  [7:0] sfr_rdata;
  wire        wdt_rst;

  int  checks = 0;
  int  fails = 0;
  bit  done = 0;
  int  v, m, p, seed_val;

  always #4 clk = ~clk;

  mcu_watchdog #(.CLK_DIV(DIV), .SEL_BASE(BASE), .RST_LEN(PLEN)) uut (
    .clk(clk), .rst(rst), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .pd_mode(pd_mode),
    .wake_irq_n(wake_irq_n), .wdt_rst(wdt_rst)
  );

  function automatic int tmo(int n);
    return DIV * ((1 << (BASE + n)) - 1);
  endfunction

  task automatic check(string req, int got, int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    sfr_wr = 1'b1; sfr_addr = a; sfr_wdata = d;
    @(negedge clk);
    sfr_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output int val);
    sfr_addr = a;
    @(negedge clk);
    val = int'(sfr_rdata);
  endtask

  task automatic do_reset();
    rst = 1'b1; pd_mode = 1'b0; wake_irq_n = 1'b1; sfr_wr = 1'b0;
    idle(3);
    rst = 1'b0;
  endtask

  task automatic enable();
    wr(8'hA6, 8'h1E);
    wr(8'hA6, 8'hE1);
  endtask

  task automatic measure(int cap, output int n);
    n = 0;
    while (wdt_rst !== 1'b1 && n < cap) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    seed_val = $urandom(32'd4242);
    idle(1);
    do_reset();

    // R1 reset state
    rd(8'hA7, v);  check("R1 select after reset", v, 0);
    check("R1 reset output idle", int'(wdt_rst), 0);

    // R2 register access
    wr(8'hA7, 8'hFD);
    rd(8'hA7, v);  check("R2 reserved bits dropped", v, 5);
    rd(8'hA6, v);  check("R2 key register reads zero", v, 0);
    rd(8'h55, v);  check("R2 unmapped reads zero", v, 0);
    for (int i = 0; i < 6; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      wr(8'hA7, d);
      rd(8'hA7, v);
      check("R2 random readback", v, int'(d & 8'h07));
    end

    // R1 disabled never fires; R5 lone E1h does not enable
    wr(8'hA7, 8'h00);
    idle(tmo(0) * 2);
    check("R1 disabled stays quiet", int'(wdt_rst), 0);
    wr(8'hA6, 8'hE1);
    idle(tmo(0) + 10);
    check("R5 lone E1h ignored", int'(wdt_rst), 0);

    // R3 R4 R7 timeouts for several selects
    foreach (seln_list[k]) begin
      do_reset();
      wr(8'hA7, 8'(seln_list[k]));
      enable();
      measure(tmo(seln_list[k]) + 50, m);
      check("R3 R4 timeout length", m, tmo(seln_list[k]));
      p = 0;
      while (wdt_rst === 1'b1 && p < 500) begin
        @(negedge clk);
        p++;
      end
      check("R7 pulse width", p, PLEN);
      if (seln_list[k] == 0) begin
        idle(tmo(0) * 2);
        check("R7 disabled after pulse", int'(wdt_rst), 0);
      end
    end

    // R5 broken sequences do not restart
    do_reset();
    enable();
    wr(8'hA6, 8'hE1);
    wr(8'hA6, 8'h1E);
    wr(8'hA6, 8'h00);
    wr(8'hA6, 8'hE1);
    measure(tmo(0) + 50, m);
    check("R5 aborted key keeps count", m + 4, tmo(0));

    // R5 repeated 1Eh re-arms; R6 service restarts count
    do_reset();
    enable();
    idle(20);
    wr(8'hA6, 8'h1E);
    wr(8'hA6, 8'h1E);
    wr(8'hA6, 8'hE1);
    measure(tmo(0) + 50, m);
    check("R5 R6 rearm then restart", m, tmo(0));

    // R6 only reset disables
    do_reset();
    enable();
    idle(20);
    do_reset();
    idle(tmo(0) + 20);
    check("R6 reset stops watchdog", int'(wdt_rst), 0);

    // R10 service on the expiry edge
    do_reset();
    enable();
    wr(8'hA6, 8'h1E);
    idle(tmo(0) - 2);
    wr(8'hA6, 8'hE1);
    check("R10 no reset on collision", int'(wdt_rst), 0);
    measure(tmo(0) + 50, m);
    check("R10 full timeout after collision", m, tmo(0));

    // R8 deep sleep freezes
    do_reset();
    enable();
    idle(10);
    pd_mode = 1'b1; idle(25); pd_mode = 1'b0;
    measure(tmo(0) + 50, m);
    check("R8 sleep delays timeout", 35 + m, tmo(0) + 25);

    // R9 wake line held low after sleep
    do_reset();
    enable();
    idle(10);
    pd_mode = 1'b1; wake_irq_n = 1'b0; idle(5);
    pd_mode = 1'b0; idle(20);
    wake_irq_n = 1'b1;
    measure(tmo(0) + 80, m);
    check("R9 hold until line high", 35 + m, tmo(0) + 25);

    // R9 line high at sleep exit gives no hold
    do_reset();
    enable();
    idle(10);
    pd_mode = 1'b1; wake_irq_n = 1'b1; idle(5);
    pd_mode = 1'b0; wake_irq_n = 1'b0; idle(20);
    wake_irq_n = 1'b1;
    measure(tmo(0) + 80, m);
    check("R9 no hold when line high", 35 + m, tmo(0) + 5);

    // R4 R8 R9 random power patterns
    for (int t = 0; t < 8; t++) begin
      int n, act, lim;
      bit hm, pp, qq;
      n = $urandom_range(0, 3);
      act = 0; hm = 0; pp = 0; qq = 1;
      do_reset();
      wr(8'hA7, 8'(n));
      enable();
      lim = tmo(n);
      while (wdt_rst !== 1'b1 && act <= lim + 2) begin
        if (!pp && $urandom_range(0, 39) == 0) pp = 1;
        else if (pp && $urandom_range(0, 7) == 0) pp = 0;
        if ($urandom_range(0, 5) == 0) qq = ~qq;
        pd_mode = pp; wake_irq_n = qq;
        @(negedge clk);
        if (!(pp || (hm && !qq))) act++;
        if (pp) hm = !qq;
        else if (qq) hm = 0;
      end
      check("R4 R8 R9 random unfrozen edges", act, lim);
      pd_mode = 1'b0; wake_irq_n = 1'b1;
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  int seln_list[4] = '{0, 1, 2, 7};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule